// File: doc/BRIEF.md
# Deinterleaving Parallel-to-Serial Lane Multiplexer

This block takes a wide parallel word and drives it out over 16 serial lanes, one bit per lane per cycle, with everything on a single fast clock. In the eight-phase ratio the word is 128 bits and one word is taken every 8 cycles. In the four-phase ratio only the low 64 bits count and one word is taken every 4 cycles. A first stage deinterleaves the word so that every lane receives its own byte or nibble stream. A second stage walks each lane through its bits, most significant first, under a 3-bit phase counter.

The 16 lanes are grouped into four 4-lane slices. In four-slice layout, each slice has its own enable input. That enable is expected to be several cycles wide, and the block cuts it down to a one-cycle load strobe on its rising edge. The strobe captures the word and realigns the slice's phase counter. In one-channel layout, the external enables are ignored. A free-running divider inside the block then produces one strobe per period, shared by all four slices. A strobe that lands before a slice has finished its word discards the remaining bits. A slice that finishes its word with no new strobe drives zeros until its next strobe.

Top module: `deint_mux`

## Requirements
- R1: While reset is high, and after reset until a slice's first load strobe, every lane of that slice drives 0.
- R2: With ratio_sel=0 (eight-phase), after a load at clock edge t, lane k drives word bit 8k+7-j in the cycle after edge t+j, for j = 0..7.
- R3: With ratio_sel=1 (four-phase), after a load at edge t, in the cycle after edge t+j (j = 0..3), even lane k drives word bit 8*(k/2)+7-j and odd lane k drives word bit 8*(k/2)+3-j. Word bits 127:64 have no effect on the lanes.
- R4: With slice_mode=0 (one channel), all slices load together at the first clock edge after reset is released and at every 8th (ratio_sel=0) or 4th (ratio_sel=1) edge after that. The slice_en inputs have no effect.
- R5: With slice_mode=1 (four slices), slice s (lanes 4s..4s+3) loads at an edge where slice_en[s] is 1 and was 0 at the previous edge, or was held low through reset. A high level of any width yields only one load.
- R6: A load captures the word_in value present at the loading edge. Its first bit appears in the cycle right after that edge.
- R7: A load that arrives before the current word's bits are all out drops the remaining bits. The new word starts from its first bit at once.
- R8: Once a slice has driven the last bit of a word (8 in eight-phase, 4 in four-phase) and no new load has come, its lanes drive 0.
- R9: In four-slice layout, a slice's loads and outputs are independent of the other slices' enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ratio_sel | input | 1 | 0: eight-phase 128-bit words, 1: four-phase 64-bit words |
| slice_mode | input | 1 | 0: one channel with internal strobe, 1: four independent slices |
| word_in | input | 128 | Parallel input word |
| slice_en | input | 4 | Per-slice external enables, slice s on bit s |
| lane_out | output | 16 | Serial lane outputs, lane k on bit k |

## Verification
A load strobe arises from inputs seen at a rising edge. The first bit of the captured word is therefore visible right after that edge, and bit j appears j edges later. The idle zero follows one period after the last load. The bench drives stimulus and samples lane_out at falling edges. For each sample it works out from its own stimulus record which edge last loaded each slice and how many edges have passed since. It then compares the whole 16-bit lane vector in every cycle, so an early or late load, a shifted bit order or a missed restart each show up as a mismatch in that exact cycle.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    localparam int WORD_W  = 128;
    localparam int BYTE_W  = 8;
    localparam int PHASE_W = 3;

    typedef enum logic {
        RATIO_EIGHT = 1'b0,
        RATIO_FOUR  = 1'b1
    } ratio_e;

    typedef struct packed {
        logic               busy;
        logic [PHASE_W-1:0] phase;
    } slice_state_t;

    // Final phase value of a word for the given ratio.
    function automatic logic [PHASE_W-1:0] final_phase(ratio_e r);
        return (r == RATIO_FOUR) ? PHASE_W'(3) : PHASE_W'(7);
    endfunction

    // Bits a lane will serialize, left-aligned so bit 7 goes out first.
    // Four-phase: lane k takes nibble k^1 (high nibble of a byte to the even lane).
    function automatic logic [BYTE_W-1:0] lane_load(logic [WORD_W-1:0] w, int k, ratio_e r);
        logic [BYTE_W-1:0] b;
        if (r == RATIO_FOUR) begin
            b = {w[4*(k^1) +: 4], 4'b0000};
        end else begin
            b = w[BYTE_W*k +: BYTE_W];
        end
        return b;
    endfunction

endpackage

// File: rtl/dsm_enable_shaper.sv
module dsm_enable_shaper
    import dsm_pkg::*;
#(
    parameter int SLICES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  ratio_e            ratio,
    input  logic              four_slices,
    input  logic [SLICES-1:0] ext_en,
    output logic [SLICES-1:0] load
);

    logic [SLICES-1:0]  en_q;
    logic [PHASE_W-1:0] div_cnt;
    logic [PHASE_W-1:0] div_last;

    assign div_last = final_phase(ratio);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            div_cnt <= '0;
        end else begin
            en_q    <= ext_en;
            div_cnt <= (div_cnt >= div_last) ? '0 : div_cnt + PHASE_W'(1);
        end
    end

    always_comb begin
        if (four_slices) begin
            load = ext_en & ~en_q;
        end else begin
            load = {SLICES{div_cnt == '0}};
        end
    end

endmodule

// File: rtl/dsm_slice_serializer.sv
module dsm_slice_serializer
    import dsm_pkg::*;
#(
    parameter int LPS = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  ratio_e                     ratio,
    input  logic                       load,
    input  logic [LPS-1:0][BYTE_W-1:0] lane_bytes,
    output logic [LPS-1:0]             bits,
    output slice_state_t               state
);

    logic [LPS-1:0][BYTE_W-1:0] hold;
    slice_state_t               st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold <= '0;
            st_q <= '0;
        end else if (load) begin
            hold       <= lane_bytes;
            st_q.busy  <= 1'b1;
            st_q.phase <= '0;
        end else if (st_q.busy) begin
            if (st_q.phase >= final_phase(ratio)) begin
                st_q.busy  <= 1'b0;
                st_q.phase <= '0;
            end else begin
                st_q.phase <= st_q.phase + PHASE_W'(1);
            end
        end
    end

    for (genvar i = 0; i < LPS; i++) begin : g_lane
        assign bits[i] = st_q.busy & hold[i][PHASE_W'(7) - st_q.phase];
    end

    assign state = st_q;

endmodule

// File: rtl/deint_mux.sv
module deint_mux
    import dsm_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int SLICES = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ratio_sel,
    input  logic               slice_mode,
    input  logic [WORD_W-1:0]  word_in,
    input  logic [SLICES-1:0]  slice_en,
    output logic [LANES-1:0]   lane_out
);

    localparam int LPS = LANES / SLICES;

    ratio_e                          ratio_q;
    logic [SLICES-1:0]               load;
    logic [LANES-1:0][BYTE_W-1:0]    lane_bytes;
    slice_state_t [SLICES-1:0]       sstate;
    logic [SLICES-1:0]               busy_v;
    logic [SLICES-1:0][PHASE_W-1:0]  phase_v;

    assign ratio_q = ratio_e'(ratio_sel);

    dsm_enable_shaper #(.SLICES(SLICES)) u_shaper (
        .clk         (clk),
        .rst         (rst),
        .ratio       (ratio_q),
        .four_slices (slice_mode),
        .ext_en      (slice_en),
        .load        (load)
    );

    // Stage one: deinterleave the word into per-lane streams.
    for (genvar k = 0; k < LANES; k++) begin : g_deint
        assign lane_bytes[k] = lane_load(word_in, k, ratio_q);
    end

    // Stage two: per-slice serialization.
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        dsm_slice_serializer #(.LPS(LPS)) u_ser (
            .clk        (clk),
            .rst        (rst),
            .ratio      (ratio_q),
            .load       (load[s]),
            .lane_bytes (lane_bytes[s*LPS +: LPS]),
            .bits       (lane_out[s*LPS +: LPS]),
            .state      (sstate[s])
        );
        assign busy_v[s]  = sstate[s].busy;
        assign phase_v[s] = sstate[s].phase;
    end

endmodule

// File: rtl/deint_mux_checker.sv
module deint_mux_checker
    import dsm_pkg::*;
#(
    parameter int LANES  = 16,
    parameter int SLICES = 4
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          ratio_sel,
    input logic                          slice_mode,
    input logic [SLICES-1:0]             load,
    input logic [SLICES-1:0]             busy_v,
    input logic [SLICES-1:0][PHASE_W-1:0] phase_v,
    input logic [LANES-1:0]              lane_out
);

    localparam int LPS = LANES / SLICES;

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> (lane_out == '0));

    // R4
    lockstep_load_chk: assert property (@(posedge clk) disable iff (rst)
        !slice_mode |-> (load == '0 || load == '1));

    for (genvar s = 0; s < SLICES; s++) begin : g_chk
        // R5
        single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
            (slice_mode && load[s]) |=> (!slice_mode || !load[s]));

        // R6
        load_starts_chk: assert property (@(posedge clk) disable iff (rst)
            load[s] |=> busy_v[s]);

        // R8
        idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !busy_v[s] |-> (lane_out[s*LPS +: LPS] == '0));

        // R2
        phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
            busy_v[s] |-> (phase_v[s] <= final_phase(ratio_e'(ratio_sel))));
    end

endmodule

bind deint_mux deint_mux_checker #(.LANES(LANES), .SLICES(SLICES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ratio_sel  (ratio_sel),
    .slice_mode (slice_mode),
    .load       (load),
    .busy_v     (busy_v),
    .phase_v    (phase_v),
    .lane_out   (lane_out)
);

// File: tb/deint_mux_test.sv
`timescale 1ns/1ps
module deint_mux_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ratio_sel = 1'b0;
    logic         slice_mode = 1'b0;
    logic [127:0] word_in = '0;
    logic [3:0]   slice_en = '0;
    logic [15:0]  lane_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    deint_mux uut (
        .clk        (clk),
        .rst        (rst),
        .ratio_sel  (ratio_sel),
        .slice_mode (slice_mode),
        .word_in    (word_in),
        .slice_en   (slice_en),
        .lane_out   (lane_out)
    );

    function automatic logic [127:0] mk_word(int seed);
        logic [127:0] w;
        for (int i = 0; i < 4; i++) begin
            w[32*i +: 32] = (32'(seed) + 32'd1) * 32'h9E3779B1 ^ (32'(i) * 32'h85EBCA6B) ^ (32'(seed) << i);
        end
        return w;
    endfunction

    // Bit of word w on lane k at step j.
    function automatic logic exp_bit(logic [127:0] w, int k, int j, bit four);
        if (!four) return w[8*k + 7 - j];
        return w[8*(k/2) + ((k % 2 == 0) ? 7 : 3) - j];
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(bit four, bit slices);
        rst = 1'b1; ratio_sel = four; slice_mode = slices; slice_en = '0;
        word_in = mk_word(77);
        repeat (3) @(negedge clk);
        check("R1 lanes zero in reset", lane_out, 16'h0000);
    endtask

    task automatic run_single(bit four, int ncyc);
        int per;
        logic [15:0] e;
        per = four ? 4 : 8;
        do_reset(four, 1'b0);
        for (int n = 0; n < ncyc; n++) begin
            rst = 1'b0;
            word_in = mk_word(n);
            slice_en = 4'($urandom);
            @(negedge clk);
            for (int k = 0; k < 16; k++) begin
                e[k] = exp_bit(mk_word(n - n % per), k, n % per, four);
            end
            check(four ? "R3/R4/R6 one-channel four-phase" : "R2/R4/R6 one-channel eight-phase",
                  lane_out, e);
        end
    endtask

    task automatic run_slices(bit four, int ncyc);
        int per[4];
        int wid[4];
        int off[4];
        int start[4];
        logic [127:0] cap[4];
        bit prev[4];
        int plen;
        logic [15:0] e;
        per = '{8, 5, 12, 9};
        wid = '{4, 4, 1, 3};
        off = '{0, 2, 5, 7};
        plen = four ? 4 : 8;
        do_reset(four, 1'b1);
        for (int s = 0; s < 4; s++) begin
            start[s] = -1; prev[s] = 1'b0; cap[s] = '0;
        end
        for (int n = 0; n < ncyc; n++) begin
            rst = 1'b0;
            word_in = mk_word(1000 + n);
            for (int s = 0; s < 4; s++) begin
                bit en;
                en = ((n + off[s]) % per[s]) < wid[s];
                slice_en[s] = en;
                if (en && !prev[s]) begin
                    start[s] = n;
                    cap[s] = word_in;
                end
                prev[s] = en;
            end
            @(negedge clk);
            for (int s = 0; s < 4; s++) begin
                for (int l = 0; l < 4; l++) begin
                    int j;
                    j = n - start[s];
                    e[4*s + l] = (start[s] >= 0 && j < plen) ? exp_bit(cap[s], 4*s + l, j, four) : 1'b0;
                end
            end
            check(four ? "R1/R3/R5/R7/R8/R9 four-slice four-phase"
                       : "R1/R2/R5/R7/R8/R9 four-slice eight-phase", lane_out, e);
        end
    endtask

    initial begin
        run_single(1'b0, 48);
        run_single(1'b1, 40);
        run_slices(1'b0, 80);
        run_slices(1'b1, 80);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 lanes zero after late reset", lane_out, 16'h0000);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1-all: actual=timeout expected=completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule